// File: doc/BRIEF.md
# Load/Store Transfer Descriptor Unit

This unit gives a processor a small bank of configuration registers that describe one outgoing direct I/O transaction. Software stages the local buffer address, the remote address, the target device identifier, a byte count and a priority. It then writes the transaction type into the launch register at index 5, and that write starts the transfer. The unit checks the descriptor, latches a request header, gives the request a transaction ID from a hardware counter, and presents it on a valid/ready request port.

Write-type requests with no acknowledgement (NWRITE and SWRITE) retire when the request handshake completes. All other types wait on a response port for a response that carries the issued ID. A status word reports busy, error, overrun, the completion code and the last issued ID. A one-cycle done pulse marks each retirement.

Top module: `lsd_top`

## Requirements
- R1: After reset the status word (index 6) reads zero, and `reqValid` and `donePulse` are low.
- R2: Writes to indices 0 to 4 (0 local address, 1 remote address, 2 device ID in bits 15:0, 3 byte count in bits 15:0, 4 priority in bits 1:0) only stage values. They read back at the same index and raise no request.
- R3: A valid write to index 5 raises `reqValid` on the next cycle. The header carries the staged local address, remote address, device ID, byte count and 2-bit priority unchanged, with the type taken from write-data bits 2:0. `reqValid` and the header hold until `reqReady`.
- R4: Type codes are 0 NREAD, 1 NWRITE, 2 NWRITE_R, 3 SWRITE, 4 ATOMIC and 5 MAINTENANCE. Codes 6 and 7 set the error bit (status bit 1), and no request is issued.
- R5: A byte count of 0 or above 256 sets the error bit, and no request is issued. Counts from 1 to 256 are accepted.
- R6: The transaction ID of the first launch after reset is 0. It rises by one per accepted launch and wraps from 255 to 0. Rejected and ignored launches use no ID.
- R7: For NWRITE and SWRITE, busy (status bit 0) clears on the cycle after the request handshake.
- R8: The other four types keep busy set until a response arrives whose `rspTid` equals the issued ID. A response with any other ID has no effect.
- R9: The completion code (status bit 3) takes `rspErr` of the matching response, or 0 for a type that retires at the handshake.
- R10: `donePulse` is high for exactly one cycle, on the cycle when busy clears.
- R11: A write to index 5 while busy is ignored. The header and ID stay unchanged, and the sticky overrun bit (status bit 2) is set. Writing 1 to bit 2 of index 6 clears it.
- R12: An accepted launch clears the error bit. Status bits 15:8 hold the last issued ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Register index for read and write |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Read data for `cfgAddr` (combinational) |
| reqValid | output | 1 | Request header valid |
| reqReady | input | 1 | Request accepted by downstream |
| reqType | output | 3 | Transaction type code |
| reqTid | output | 8 | Hardware-assigned transaction ID |
| reqDestId | output | 16 | Target device ID |
| reqRemoteAddr | output | 32 | Remote destination address |
| reqLocalAddr | output | 32 | Local memory address |
| reqByteCnt | output | 9 | Transfer byte count |
| reqPrio | output | 2 | Packet priority |
| rspValid | input | 1 | Response valid |
| rspTid | input | 8 | Transaction ID of the response |
| rspErr | input | 1 | Response reports an error |
| donePulse | output | 1 | One-cycle retirement pulse |

## Verification
The bench sweeps all eight type codes. A design that decoded the type wrongly would issue the illegal codes 6 and 7, or would retire a non-posted request at the handshake. It also sweeps byte counts around the limits 0, 1, 256 and 257; an off-by-one bound would accept 0 or 257, or reject 256. A wrong-ID response is sent before every matching one, to catch a design that drops busy on any response. The bench drives more than 256 launches to check the ID wrap, and it writes index 5 while busy to check that the header and ID stay unchanged and that the sticky overrun bit behaves.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int unsigned REG_IDX_W  = 3;
  localparam int unsigned REG_LAUNCH = 5;
  localparam int unsigned REG_STATUS = 6;

  localparam logic [2:0] TYPE_NWRITE = 3'd1;
  localparam logic [2:0] TYPE_SWRITE = 3'd3;
  localparam logic [2:0] TYPE_LAST   = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} ctrlState_e;

  typedef struct packed {
    logic launch;
    logic reject;
    logic overrun;
    logic retire;
    logic retireErr;
  } ctrlStrb_t;

  function automatic logic typeLegal(input logic [2:0] t);
    return t <= TYPE_LAST;
  endfunction

  function automatic logic typePosted(input logic [2:0] t);
    return (t == TYPE_NWRITE) || (t == TYPE_SWRITE);
  endfunction
endpackage

// File: rtl/lsd_datapath.sv
module lsd_datapath
  import lsd_pkg::*;
#(
  parameter int unsigned CFG_W     = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ID_W      = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRIO_W    = 2,
  parameter int unsigned TID_W     = 8,
  parameter int unsigned MAX_BYTES = 256,
  localparam int unsigned XFER_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [REG_IDX_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]     cfgWrData,
  output logic [CFG_W-1:0]     cfgRdData,
  input  ctrlStrb_t            strb,
  input  logic                 busy,
  output logic                 launchWr,
  output logic                 descOk,
  output logic                 curPosted,
  input  logic [TID_W-1:0]     rspTid,
  output logic                 rspMatch,
  output logic [2:0]           hdrType,
  output logic [TID_W-1:0]     curTid,
  output logic [ID_W-1:0]      hdrDest,
  output logic [ADDR_W-1:0]    hdrRemote,
  output logic [ADDR_W-1:0]    hdrLocal,
  output logic [XFER_W-1:0]    hdrCnt,
  output logic [PRIO_W-1:0]    hdrPrio
);
  logic [ADDR_W-1:0] stgLocal, stgRemote;
  logic [ID_W-1:0]   stgDest;
  logic [CNT_W-1:0]  stgCnt;
  logic [PRIO_W-1:0] stgPrio;
  logic [TID_W-1:0]  tidNext;
  logic              errFlag, overrunFlag, compErr;
  logic              clrOverrun;

  assign launchWr   = cfgWrEn && (cfgAddr == REG_IDX_W'(REG_LAUNCH));
  assign clrOverrun = cfgWrEn && (cfgAddr == REG_IDX_W'(REG_STATUS)) && cfgWrData[2];
  assign descOk     = typeLegal(cfgWrData[2:0]) && (stgCnt != '0)
                      && (stgCnt <= CNT_W'(MAX_BYTES));
  assign curPosted  = typePosted(hdrType);
  assign rspMatch   = (rspTid == curTid);

  // staging registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgLocal  <= '0;
      stgRemote <= '0;
      stgDest   <= '0;
      stgCnt    <= '0;
      stgPrio   <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        3'd0: stgLocal  <= cfgWrData[ADDR_W-1:0];
        3'd1: stgRemote <= cfgWrData[ADDR_W-1:0];
        3'd2: stgDest   <= cfgWrData[ID_W-1:0];
        3'd3: stgCnt    <= cfgWrData[CNT_W-1:0];
        3'd4: stgPrio   <= cfgWrData[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // header latch and hardware ID allocation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrType   <= '0;
      curTid    <= '0;
      tidNext   <= '0;
      hdrDest   <= '0;
      hdrRemote <= '0;
      hdrLocal  <= '0;
      hdrCnt    <= '0;
      hdrPrio   <= '0;
    end else if (strb.launch) begin
      hdrType   <= cfgWrData[2:0];
      curTid    <= tidNext;
      tidNext   <= tidNext + 1'b1;
      hdrDest   <= stgDest;
      hdrRemote <= stgRemote;
      hdrLocal  <= stgLocal;
      hdrCnt    <= stgCnt[XFER_W-1:0];
      hdrPrio   <= stgPrio;
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag     <= 1'b0;
      overrunFlag <= 1'b0;
      compErr     <= 1'b0;
    end else begin
      if (strb.reject)      errFlag <= 1'b1;
      else if (strb.launch) errFlag <= 1'b0;
      if (strb.overrun)     overrunFlag <= 1'b1;
      else if (clrOverrun)  overrunFlag <= 1'b0;
      if (strb.retire)      compErr <= strb.retireErr;
    end
  end

  always_comb begin
    case (cfgAddr)
      3'd0:    cfgRdData = CFG_W'(stgLocal);
      3'd1:    cfgRdData = CFG_W'(stgRemote);
      3'd2:    cfgRdData = CFG_W'(stgDest);
      3'd3:    cfgRdData = CFG_W'(stgCnt);
      3'd4:    cfgRdData = CFG_W'(stgPrio);
      3'd5:    cfgRdData = CFG_W'(hdrType);
      3'd6:    cfgRdData = CFG_W'({curTid, 4'b0, compErr, overrunFlag, errFlag, busy});
      default: cfgRdData = '0;
    endcase
  end

  AST_TID_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> (tidNext == curTid + 1'b1)); // R6
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(curTid) && $stable(hdrType) && $stable(hdrRemote))); // R11
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> errFlag); // R4
endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
  import lsd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      launchWr,
  input  logic      descOk,
  input  logic      curPosted,
  input  logic      reqReady,
  input  logic      rspValid,
  input  logic      rspMatch,
  input  logic      rspErr,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      reqValid,
  output logic      donePulse
);
  ctrlState_e state, stateNxt;
  logic idle;

  assign idle     = (state == ST_IDLE);
  assign busy     = !idle;
  assign reqValid = (state == ST_ISSUE);

  always_comb begin
    strb           = '0;
    strb.launch    = launchWr && idle && descOk;
    strb.reject    = launchWr && idle && !descOk;
    strb.overrun   = launchWr && !idle;
    strb.retire    = ((state == ST_ISSUE) && reqReady && curPosted)
                     || ((state == ST_WAIT) && rspValid && rspMatch);
    strb.retireErr = (state == ST_WAIT) && rspErr;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (strb.launch) stateNxt = ST_ISSUE;
      ST_ISSUE: if (reqReady) stateNxt = curPosted ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (rspValid && rspMatch) stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
    end else begin
      state     <= stateNxt;
      donePulse <= strb.retire;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid); // R3
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (launchWr && idle && !descOk) |=> !busy); // R5
  AST_POSTED_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && curPosted) |=> !busy); // R7
  AST_WAIT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && !(rspValid && rspMatch)) |=> busy); // R8
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R10
  AST_DONE_AT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> donePulse); // R10
endmodule

// File: rtl/lsd_top.sv
module lsd_top
  import lsd_pkg::*;
#(
  parameter int unsigned CFG_W     = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ID_W      = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRIO_W    = 2,
  parameter int unsigned TID_W     = 8,
  parameter int unsigned MAX_BYTES = 256,
  localparam int unsigned XFER_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [REG_IDX_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]     cfgWrData,
  output logic [CFG_W-1:0]     cfgRdData,
  output logic                 reqValid,
  input  logic                 reqReady,
  output logic [2:0]           reqType,
  output logic [TID_W-1:0]     reqTid,
  output logic [ID_W-1:0]      reqDestId,
  output logic [ADDR_W-1:0]    reqRemoteAddr,
  output logic [ADDR_W-1:0]    reqLocalAddr,
  output logic [XFER_W-1:0]    reqByteCnt,
  output logic [PRIO_W-1:0]    reqPrio,
  input  logic                 rspValid,
  input  logic [TID_W-1:0]     rspTid,
  input  logic                 rspErr,
  output logic                 donePulse
);
  ctrlStrb_t strb;
  logic busy, launchWr, descOk, curPosted, rspMatch;

  lsd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .launchWr(launchWr), .descOk(descOk),
    .curPosted(curPosted), .reqReady(reqReady), .rspValid(rspValid),
    .rspMatch(rspMatch), .rspErr(rspErr), .strb(strb), .busy(busy),
    .reqValid(reqValid), .donePulse(donePulse)
  );

  lsd_datapath #(
    .CFG_W(CFG_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W),
    .PRIO_W(PRIO_W), .TID_W(TID_W), .MAX_BYTES(MAX_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .strb(strb), .busy(busy),
    .launchWr(launchWr), .descOk(descOk), .curPosted(curPosted),
    .rspTid(rspTid), .rspMatch(rspMatch), .hdrType(reqType), .curTid(reqTid),
    .hdrDest(reqDestId), .hdrRemote(reqRemoteAddr), .hdrLocal(reqLocalAddr),
    .hdrCnt(reqByteCnt), .hdrPrio(reqPrio)
  );

  AST_HDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> ($stable(reqTid) && $stable(reqLocalAddr)
                                 && $stable(reqByteCnt))); // R3
endmodule

// File: tb/sim_lsd_top.sv
`timescale 1ns/1ps
module sim_lsd_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid, reqReady = 1'b0;
  logic [2:0]  reqType;
  logic [7:0]  reqTid;
  logic [15:0] reqDestId;
  logic [31:0] reqRemoteAddr, reqLocalAddr;
  logic [8:0]  reqByteCnt;
  logic [1:0]  reqPrio;
  logic        rspValid = 1'b0, rspErr = 1'b0;
  logic [7:0]  rspTid = '0;
  logic        donePulse;

  int checks = 0, failures = 0;
  int expTid = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lsd_top u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  task automatic handshake();
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
  endtask

  task automatic respond(logic [7:0] t, logic e);
    rspValid = 1'b1; rspTid = t; rspErr = e;
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic stage(logic [31:0] la, logic [31:0] ra, logic [15:0] dv,
                       logic [15:0] cnt, logic [1:0] pr);
    wr(0, la); wr(1, ra); wr(2, {16'h0, dv}); wr(3, {16'h0, cnt}); wr(4, {30'h0, pr});
  endtask

  // retire the active request correctly according to its type
  task automatic finish_req(logic [2:0] t, logic e, string req);
    logic [31:0] s;
    if (t == 3'd1 || t == 3'd3) begin
      handshake();
      rd(6, s);
      chk({req, " R7 busy clear"}, s[0], 0);
      chk({req, " R10 done"}, donePulse, 1);
      chk({req, " R9 code"}, s[3], 0);
    end else begin
      handshake();
      respond(reqTid + 8'd1, 1'b0);
      rd(6, s);
      chk({req, " R8 wrong id"}, s[0], 1);
      chk({req, " R8 no done"}, donePulse, 0);
      respond(reqTid, e);
      rd(6, s);
      chk({req, " R8 busy clear"}, s[0], 0);
      chk({req, " R10 done"}, donePulse, 1);
      chk({req, " R9 code"}, s[3], e);
    end
    @(negedge clk);
    chk({req, " R10 one cycle"}, donePulse, 0);
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(6, s);
    chk("R1 status", s, 0);
    chk("R1 reqValid", reqValid, 0);
    chk("R1 done", donePulse, 0);

    // R2 staging
    stage(32'hA000_1000, 32'hB000_2000, 16'h1234, 16'd16, 2'd2);
    rd(0, s); chk("R2 local", s, 32'hA000_1000);
    rd(1, s); chk("R2 remote", s, 32'hB000_2000);
    rd(2, s); chk("R2 dest", s, 32'h1234);
    rd(3, s); chk("R2 count", s, 16);
    rd(4, s); chk("R2 prio", s, 2);
    chk("R2 no request", reqValid, 0);

    // R3 R4 type sweep
    for (int t = 0; t < 8; t++) begin
      stage(32'h100 * t, 32'hC000_0000 + t, 16'(t + 7), 16'(8 + t), 2'(t));
      wr(5, 32'(t));
      rd(6, s);
      if (t > 5) begin
        chk("R4 illegal no req", reqValid, 0);
        chk("R4 illegal err", s[1], 1);
        chk("R4 illegal idle", s[0], 0);
      end else begin
        chk("R3 valid", reqValid, 1);
        chk("R3 type", reqType, t);
        chk("R6 tid", reqTid, expTid);
        chk("R12 tid status", s[15:8], expTid);
        chk("R3 local", reqLocalAddr, 32'h100 * t);
        chk("R3 remote", reqRemoteAddr, 32'hC000_0000 + t);
        chk("R3 dest", reqDestId, t + 7);
        chk("R3 count", reqByteCnt, 8 + t);
        chk("R3 prio", reqPrio, t % 4);
        @(negedge clk);
        chk("R3 hold", reqValid, 1);
        expTid++;
        finish_req(3'(t), (t == 4), "sweep");
      end
    end

    // R12 error cleared by accepted launch
    stage(32'h1, 32'h2, 16'h3, 16'd4, 2'd1);
    wr(5, 32'd0);
    rd(6, s);
    chk("R12 err cleared", s[1], 0);
    expTid++;
    finish_req(3'd0, 1'b0, "r12");

    // R5 byte count sweep
    begin
      int cnts[7] = '{0, 1, 255, 256, 257, 300, 65535};
      foreach (cnts[i]) begin
        stage(32'h55, 32'h66, 16'h77, 16'(cnts[i]), 2'd3);
        wr(5, 32'd1);
        rd(6, s);
        if (cnts[i] >= 1 && cnts[i] <= 256) begin
          chk("R5 accept", reqValid, 1);
          chk("R5 count", reqByteCnt, cnts[i]);
          chk("R5 err low", s[1], 0);
          expTid++;
          finish_req(3'd1, 1'b0, "cnt");
        end else begin
          chk("R5 reject", reqValid, 0);
          chk("R5 err", s[1], 1);
        end
      end
    end

    // R11 overrun while busy
    stage(32'hAAAA, 32'hBBBB, 16'hCC, 16'd32, 2'd0);
    wr(5, 32'd2);
    chk("R11 launched", reqValid, 1);
    wr(1, 32'hDEAD);
    wr(5, 32'd4);
    rd(6, s);
    chk("R11 overrun set", s[2], 1);
    chk("R11 type kept", reqType, 2);
    chk("R11 tid kept", reqTid, expTid % 256);
    chk("R11 remote kept", reqRemoteAddr, 32'hBBBB);
    expTid++;
    finish_req(3'd2, 1'b0, "ovr");
    rd(6, s);
    chk("R11 sticky", s[2], 1);
    wr(6, 32'h4);
    rd(6, s);
    chk("R11 cleared", s[2], 0);

    // R6 wrap through 255
    stage(32'h0, 32'h0, 16'h0, 16'd1, 2'd0);
    while (expTid < 260) begin
      wr(5, 32'd3);
      chk("R6 wrap tid", reqTid, expTid % 256);
      expTid++;
      handshake();
    end
    rd(6, s);
    chk("R6 last tid status", s[15:8], (expTid - 1) % 256);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule